// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 12-bit sampling converter with a three-wire serial link plus a convert strobe. A one-cycle start request with a 2-bit channel configuration raises the convert strobe and holds it for a fixed conversion wait. The block then drops the strobe, which enables the converter's data output, and issues one shift-clock pulse per result bit. The received bits are captured on each rising shift-clock edge, most significant bit first. The configuration goes out on the converter's data input during the first two pulses.

The converter applies a configuration to the conversion that follows the frame in which it arrived. Each result is therefore tagged with the channel requested one frame earlier. A sleep-enable input keeps the strobe high between reads so the converter can power down. When a read starts from that state, the strobe is first pulled low for one bit time so that a fresh rising edge starts a new conversion.

Top module: `adc_read_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `conv_o`, `sck_o`, `sdi_o`, `busy_o` and `rdy_o` are low and `data_o` and `ch_o` are zero. The sleep-enable input has no effect during reset.
- R2: A start request accepted in idle drives `conv_o` high for exactly CONV_CYC cycles, beginning in the cycle after the request when the strobe was low.
- R3: After `conv_o` falls, exactly DATA_W shift-clock pulses follow. Each pulse is HALF_DIV cycles low and then HALF_DIV cycles high. `sck_o` is never high while `conv_o` is high, and it is low whenever the block is idle.
- R4: `sdo_i` is sampled at each rising shift-clock edge. The first sample is bit DATA_W-1 of `data_o` and the last sample is bit 0.
- R5: `sdi_o` carries `cfg_i[1]` at the first rising shift-clock edge and `cfg_i[0]` at the second, using the values captured at the start request. It is low at all other times.
- R6: `ch_o` reports the configuration requested in the previous accepted frame. The first frame after reset reports channel 0.
- R7: `rdy_o` is high for exactly one cycle, the cycle in which the last rising shift-clock edge appears. `data_o` and `ch_o` change only at that moment and hold until the next one.
- R8: `busy_o` is high from the cycle after an accepted start until HALF_DIV cycles after the last rising shift-clock edge, when the shift clock returns low.
- R9: A start request made while `busy_o` is high is ignored. The frame timing, the transmitted configuration and the result tag are unaffected.
- R10: In idle, `conv_o` follows `sleep_en_i` one cycle later. If `conv_o` is high when a start is accepted, it goes low for 2*HALF_DIV cycles before the CONV_CYC high period of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle read request |
| cfg_i | input | CFG_W | Channel configuration sent in this frame |
| sleep_en_i | input | 1 | Keep the convert strobe high while idle |
| conv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Shift clock to the converter, idles low |
| sdi_o | output | 1 | Configuration bits to the converter |
| sdo_i | input | 1 | Result bits from the converter |
| busy_o | output | 1 | A frame is in progress |
| rdy_o | output | 1 | One-cycle result-valid pulse |
| data_o | output | DATA_W | Last assembled result |
| ch_o | output | CFG_W | Configuration the result belongs to |

## Verification
A wrong sequencer state or counter shows up at once as a convert strobe or shift-clock level that differs from the computed frame timeline. The bench compares these outputs every cycle, so such a fault is seen within one cycle of the first wrong edge. A wrong bit index or shift register corrupts `sdi_o` during the first two pulses, or corrupts the assembled word. In that case the converter model in the bench returns a different channel's value, or the word itself is wrong, and the error is seen at the `rdy_o` pulse of that frame or of the next one. A lost or doubled channel tag appears as a tag mismatch at the next result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_CONV  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_TAIL  = 3'd4
  } rd_state_e;

endpackage

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
  import adc_rd_pkg::*;
#(
  parameter int CONV_CYC = 8,
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 12,
  parameter int BIT_W    = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sleep_en_i,
  output rd_state_e        state_o,
  output logic             conv_o,
  output logic             sck_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             accept_o,
  output logic             sample_o,
  output logic             last_o
);

  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int MAX_CYC = (CONV_CYC > GAP_CYC) ? CONV_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rd_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             conv_q, conv_n;
  logic             sck_q, sck_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    conv_n  = conv_q;
    sck_n   = sck_q;
    case (state_q)
      ST_IDLE: begin
        conv_n = sleep_en_i;
        cnt_n  = '0;
        if (start_i) begin
          bit_n = '0;
          if (conv_q) begin
            state_n = ST_GAP;
            conv_n  = 1'b0;
          end else begin
            state_n = ST_CONV;
            conv_n  = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_END) begin
          state_n = ST_CONV;
          conv_n  = 1'b1;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_q == CONV_END) begin
          state_n = ST_SHIFT;
          conv_n  = 1'b0;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == HALF_END) begin
          sck_n = 1'b1;
          if (bit_q == LAST_BIT) begin
            state_n = ST_TAIL;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else if (cnt_q == BIT_END) begin
          sck_n = 1'b0;
          cnt_n = '0;
          bit_n = bit_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_TAIL: begin
        if (cnt_q == HALF_END) begin
          sck_n   = 1'b0;
          state_n = ST_IDLE;
          conv_n  = sleep_en_i;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        state_n = ST_IDLE;
        conv_n  = 1'b0;
        sck_n   = 1'b0;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      conv_q  <= 1'b0;
      sck_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      conv_q  <= conv_n;
      sck_q   <= sck_n;
    end
  end

  assign state_o  = state_q;
  assign conv_o   = conv_q;
  assign sck_o    = sck_q;
  assign bit_o    = bit_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign sample_o = (state_q == ST_SHIFT) && (cnt_q == HALF_END);
  assign last_o   = sample_o && (bit_q == LAST_BIT);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              shifting_i,
  input  logic              sample_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              sdo_i,
  output logic              sdi_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DATA_W-1:0] word_o
);

  logic [CFG_W-1:0]  cfg_q, cfg_n;
  logic [DATA_W-1:0] sh_q, sh_n;

  always_comb begin
    cfg_n = cfg_q;
    sh_n  = sh_q;
    if (accept_i) begin
      cfg_n = cfg_i;
      sh_n  = '0;
    end else if (sample_i) begin
      sh_n = {sh_q[DATA_W-2:0], sdo_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sh_q  <= '0;
    end else begin
      cfg_q <= cfg_n;
      sh_q  <= sh_n;
    end
  end

  // configuration bits go out MSB first while bit index < CFG_W
  always_comb begin
    sdi_o = 1'b0;
    for (int i = 0; i < CFG_W; i++) begin
      if (shifting_i && (bit_i == BIT_W'(i))) begin
        sdi_o = cfg_q[CFG_W-1-i];
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign word_o = {sh_q[DATA_W-2:0], sdo_i};

endmodule

// File: rtl/adc_rd_result.sv
module adc_rd_result #(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CFG_W-1:0]  ch_o
);

  logic [DATA_W-1:0] data_q, data_n;
  logic [CFG_W-1:0]  tag_q, tag_n;
  logic [CFG_W-1:0]  prev_q, prev_n;
  logic              rdy_q;

  always_comb begin
    data_n = data_q;
    tag_n  = tag_q;
    prev_n = prev_q;
    if (last_i) begin
      data_n = word_i;
      tag_n  = prev_q;
      prev_n = cfg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tag_q  <= '0;
      prev_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      tag_q  <= tag_n;
      prev_q <= prev_n;
      rdy_q  <= last_i;
    end
  end

  assign rdy_o  = rdy_q;
  assign data_o = data_q;
  assign ch_o   = tag_q;

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CONV_CYC = 8,
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 12,
  parameter int CFG_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              sleep_en_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  input  logic              sdo_i,
  output logic              busy_o,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CFG_W-1:0]  ch_o
);

  localparam int BIT_W = $clog2(DATA_W);

  rd_state_e         state;
  logic [BIT_W-1:0]  bit_idx;
  logic              accept;
  logic              sample;
  logic              last;
  logic [CFG_W-1:0]  cfg_held;
  logic [DATA_W-1:0] word;

  adc_rd_fsm #(
    .CONV_CYC (CONV_CYC),
    .HALF_DIV (HALF_DIV),
    .DATA_W   (DATA_W),
    .BIT_W    (BIT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sleep_en_i (sleep_en_i),
    .state_o    (state),
    .conv_o     (conv_o),
    .sck_o      (sck_o),
    .bit_o      (bit_idx),
    .accept_o   (accept),
    .sample_o   (sample),
    .last_o     (last)
  );

  adc_rd_shift #(
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W),
    .BIT_W  (BIT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .cfg_i      (cfg_i),
    .shifting_i (state == ST_SHIFT),
    .sample_i   (sample),
    .bit_i      (bit_idx),
    .sdo_i      (sdo_i),
    .sdi_o      (sdi_o),
    .cfg_o      (cfg_held),
    .word_o     (word)
  );

  adc_rd_result #(
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W)
  ) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .last_i (last),
    .word_i (word),
    .cfg_i  (cfg_held),
    .rdy_o  (rdy_o),
    .data_o (data_o),
    .ch_o   (ch_o)
  );

  assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk #(
  parameter int DATA_W = 12,
  parameter int CFG_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              conv_o,
  input logic              sck_o,
  input logic              busy_o,
  input logic              rdy_o,
  input logic [DATA_W-1:0] data_o,
  input logic [CFG_W-1:0]  ch_o
);

  // R3
  sck_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !conv_o);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sck_o);

  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  // R7
  rdy_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (busy_o && sck_o));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> ($stable(data_o) && $stable(ch_o)));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && $past(conv_o)) |-> !conv_o);

endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(
  .DATA_W (DATA_W),
  .CFG_W  (CFG_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .conv_o  (conv_o),
  .sck_o   (sck_o),
  .busy_o  (busy_o),
  .rdy_o   (rdy_o),
  .data_o  (data_o),
  .ch_o    (ch_o)
);

// File: tb/adc_read_ctrl_bench.sv
`timescale 1ns/1ps
module adc_read_ctrl_bench;

  localparam int C  = 9;
  localparam int H  = 2;
  localparam int DW = 12;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [CW-1:0] cfg_i;
  logic          sleep_en_i;
  logic          conv_o, sck_o, sdi_o, sdo_i, busy_o, rdy_o;
  logic [DW-1:0] data_o;
  logic [CW-1:0] ch_o;

  int checks = 0;
  int errors = 0;

  adc_read_ctrl #(.CONV_CYC(C), .HALF_DIV(H), .DATA_W(DW), .CFG_W(CW)) u_adc_read_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .sleep_en_i(sleep_en_i), .conv_o(conv_o), .sck_o(sck_o), .sdi_o(sdi_o),
    .sdo_i(sdo_i), .busy_o(busy_o), .rdy_o(rdy_o), .data_o(data_o), .ch_o(ch_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- converter model ----------------
  logic [DW-1:0] ch_val [4];
  logic [DW-1:0] adc_res = '0;
  logic [DW-1:0] adc_sh  = '0;
  logic [1:0]    adc_mux = '0;
  logic [1:0]    adc_new = '0;
  int            adc_cfg_n = 0;

  initial sdo_i = 1'b0;

  always @(posedge conv_o) adc_res = ch_val[adc_mux];
  always @(negedge conv_o) begin
    adc_sh    = adc_res;
    sdo_i     = adc_sh[DW-1];
    adc_cfg_n = 0;
  end
  always @(negedge sck_o) if (!conv_o) begin
    adc_sh = adc_sh << 1;
    sdo_i  = adc_sh[DW-1];
  end
  always @(posedge sck_o) if (!conv_o && adc_cfg_n < 2) begin
    adc_new = {adc_new[0], sdi_o};
    adc_cfg_n++;
    if (adc_cfg_n == 2) adc_mux = adc_new;
  end

  // ---------------- cycle reference model ----------------
  int            t = -1;
  int            g = 0;
  logic          mconv = 1'b0;
  logic [CW-1:0] mcfg = '0;
  logic [CW-1:0] prev_req = '0;
  logic [DW-1:0] exp_data = '0;
  logic [CW-1:0] exp_tag = '0;
  logic [DW-1:0] hold_data = '0;
  logic [CW-1:0] hold_tag = '0;

  function automatic int s0_f();
    return g + C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1; mconv = 1'b0; prev_req = '0; hold_data = '0; hold_tag = '0;
    end else if (t < 0) begin
      if (start_i) begin
        t = 0;
        g = mconv ? 2 * H : 0;
        mcfg = cfg_i;
        exp_data = ch_val[prev_req];
        exp_tag = prev_req;
        prev_req = cfg_i;
      end else begin
        mconv = sleep_en_i;
      end
    end else begin
      t++;
      if (t == s0_f() + (2 * DW - 1) * H) begin
        hold_data = exp_data;
        hold_tag  = exp_tag;
      end
      if (t == s0_f() + 2 * DW * H) begin
        t = -1;
        mconv = sleep_en_i;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    int e_conv, e_sck, e_busy, e_rdy, e_sdi, s0, b;
    s0 = s0_f();
    if (t < 0) begin
      e_conv = mconv; e_sck = 0; e_busy = 0; e_rdy = 0; e_sdi = 0;
    end else begin
      e_busy = 1;
      e_conv = (t >= g && t < g + C) ? 1 : 0;
      e_sck = 0; e_sdi = 0;
      if (t >= s0) begin
        b = (t - s0) / (2 * H);
        e_sck = (((t - s0) % (2 * H)) >= H) ? 1 : 0;
        if (b < CW) e_sdi = mcfg[CW - 1 - b];
      end
      e_rdy = (t == s0 + (2 * DW - 1) * H) ? 1 : 0;
    end
    chk("R2/R10 conv", conv_o, e_conv);
    chk("R3 sck", sck_o, e_sck);
    chk("R5 sdi", sdi_o, e_sdi);
    chk("R8 busy", busy_o, e_busy);
    chk("R7 rdy", rdy_o, e_rdy);
    chk("R4 data", data_o, hold_data);
    chk("R6 tag", ch_o, hold_tag);
  end

  task automatic set_vals(input int k);
    for (int c = 0; c < 4; c++) ch_val[c] = DW'((k * 613 + c * 1111 + 'h2A5) & 'hFFF);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (t >= 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input int c, input int k);
    set_vals(k);
    @(negedge clk);
    start_i = 1'b1;
    cfg_i = CW'(c);
    @(negedge clk);
    start_i = 1'b0;
    cfg_i = '0;
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; sleep_en_i = 1'b1;
    set_vals(0);
    repeat (4) @(negedge clk);
    // R1: reset state, sleep enable ignored during reset
    chk("R1 conv", conv_o, 0);
    chk("R1 sck", sck_o, 0);
    chk("R1 sdi", sdi_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 rdy", rdy_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 tag", ch_o, 0);
    sleep_en_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 R5 R6: several channel patterns
    frame(2, 1);
    frame(1, 2);
    frame(3, 3);
    frame(0, 4);
    frame(3, 5);

    // R9: start requests while busy are ignored
    set_vals(6);
    @(negedge clk);
    start_i = 1'b1; cfg_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0; cfg_i = '0;
    repeat (5) @(negedge clk);
    start_i = 1'b1; cfg_i = 2'd2;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1; cfg_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0; cfg_i = '0;
    wait_idle();
    frame(2, 7);

    // R10: sleep mode holds strobe high, re-arms with a low gap
    sleep_en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle strobe high", conv_o, 1);
    frame(1, 8);
    frame(0, 9);
    sleep_en_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 idle strobe low", conv_o, 0);
    frame(3, 10);
    frame(2, 11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule